// File: doc/BRIEF.md
# Debug Pipeline Claim Controller

This block lets a debug unit take the processor pipeline away from the base datapath. It watches the instruction word held in the decode stage. When that word is a break instruction, it claims the instruction before the base datapath can raise a software trap on it. When a debug host asks for a suspend, it claims whatever instruction is decoded next, without looking at it. A claimed instruction is never executed, so execution later restarts from the current PC.

The claim follows a fixed handshake with the pipeline arbiter. The block pulls its active-low recognised line low and waits for the arbiter's enable. It then lets go of the recognised line and raises acknowledge, which keeps the pipeline stalled. When the arbiter grants the pipeline, the block reports to the higher-level debug controller. A resume request drops acknowledge and returns the pipeline to the processor.

A branch delay slot would make the restart PC ambiguous. So the block never starts a claim while the decode stage holds a delay-slot instruction. It finds delay slots from an external hint, or by decoding the instruction that last left the decode stage.

Top module: `dbg_claim_ctrl`

## Requirements
- R1: After a synchronous reset: `ri_n` is 1; `ack`, `brk_note` and `susp_ack` are 0; no suspend is pending.
- R2: A break instruction (bits 31:26 = 0, bits 5:0 = 0x0D) decoded in the idle state outside a delay slot drives `ri_n` low on the next cycle. On that same cycle only, `brk_note` is high.
- R3: A `host_suspend` in the idle state outside a delay slot drives `ri_n` low on the next cycle, whatever the instruction. `brk_note` stays 0 in this case.
- R4: The decode stage is a delay slot when `slot_in` is 1, or when the last instruction taken with `id_adv` = 1 was a branch or jump. Branches are opcodes 1, 4, 5, 6 and 7. Jumps are opcodes 2 and 3, and opcode 0 with funct 0x08 or 0x09. No claim starts in a delay slot. A suspend raised there is remembered and claimed on the cycle after the first idle cycle outside a delay slot.
- R5: `ri_n` stays low until `arb_en` is sampled high. On the following cycle `ri_n` is 1 and `ack` is 1.
- R6: `susp_ack` is 1 exactly when `ack` is held and `arb_grant` is 1.
- R7: A `host_resume` sampled while `ack` is held makes `ack` and `susp_ack` 0 on the next cycle. Claims are accepted again one cycle after that. A resume at any other time has no effect.
- R8: A `host_suspend` while `ack` is held is ignored. `ack` and `susp_ack` keep their values, and no extra claim follows the resume.
- R9: A break instruction in a delay slot is not claimed. `ri_n` stays 1 and `brk_note` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pipeline clock |
| rst | input | 1 | Synchronous active-high reset |
| id_instr | input | IW | Instruction word in the decode stage |
| id_adv | input | 1 | Decode stage hands its instruction onward this cycle |
| slot_in | input | 1 | Pipeline flags the decoded instruction as a delay slot |
| host_suspend | input | 1 | Suspend request from the debug controller |
| host_resume | input | 1 | Resume request from the debug controller |
| arb_en | input | 1 | Arbiter enables the claim |
| arb_grant | input | 1 | Arbiter grants the pipeline |
| ri_n | output | 1 | Recognised line toward the arbiter, active low |
| ack | output | 1 | Acknowledge that holds the stall |
| brk_note | output | 1 | One-cycle break notification to the debug controller |
| susp_ack | output | 1 | Processor stalled under debug control |

## Verification
The assertions check four things on every cycle: a claim never starts in a delay slot, the enable-to-acknowledge step, the single-cycle width of the break pulse, and the link between `susp_ack`, `ack` and grant. They also check that a held acknowledge drops only on resume. Other behaviours need the bench's scenarios, which compare every output against a cycle model of the requirements. These include a suspend remembered across a delay slot, a suspend ignored during a hold, and a break hidden in a delay slot. The same applies to the exact opcode coverage of the decoder.

// File: rtl/dbgc_pkg.sv
package dbgc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CLAIM   = 3'd1,
        ST_WAIT_EN = 3'd2,
        ST_HOLD    = 3'd3,
        ST_RELEASE = 3'd4
    } dbg_state_e;

    typedef struct packed {
        logic brk;
        logic br;
        logic jmp;
    } insn_class_t;

    localparam int unsigned OPC_W = 6;
    localparam int unsigned FN_W  = 6;

    localparam logic [OPC_W-1:0] OP_SPECIAL = 6'd0;
    localparam logic [OPC_W-1:0] OP_REGIMM  = 6'd1;
    localparam logic [OPC_W-1:0] OP_J       = 6'd2;
    localparam logic [OPC_W-1:0] OP_JAL     = 6'd3;
    localparam logic [OPC_W-1:0] OP_BEQ     = 6'd4;
    localparam logic [OPC_W-1:0] OP_BNE     = 6'd5;
    localparam logic [OPC_W-1:0] OP_BLEZ    = 6'd6;
    localparam logic [OPC_W-1:0] OP_BGTZ    = 6'd7;

    localparam logic [FN_W-1:0] FN_JR    = 6'h08;
    localparam logic [FN_W-1:0] FN_JALR  = 6'h09;
    localparam logic [FN_W-1:0] FN_BREAK = 6'h0D;

    function automatic insn_class_t classify(input logic [OPC_W-1:0] op,
                                             input logic [FN_W-1:0]  fn);
        insn_class_t c;
        c.brk = (op == OP_SPECIAL) && (fn == FN_BREAK);
        c.jmp = (op == OP_J) || (op == OP_JAL) ||
                ((op == OP_SPECIAL) && ((fn == FN_JR) || (fn == FN_JALR)));
        c.br  = (op == OP_REGIMM) || (op == OP_BEQ) || (op == OP_BNE) ||
                (op == OP_BLEZ) || (op == OP_BGTZ);
        return c;
    endfunction

endpackage

// File: rtl/dbgc_decode.sv
module dbgc_decode
    import dbgc_pkg::*;
#(
    parameter int unsigned IW = 32
) (
    input  logic [IW-1:0] instr,
    output insn_class_t   cls
);
    localparam int unsigned OPC_LSB = IW - OPC_W;

    logic [OPC_W-1:0] opc;
    logic [FN_W-1:0]  fnc;
    logic             unused_mid_bits;

    assign opc             = instr[IW-1:OPC_LSB];
    assign fnc             = instr[FN_W-1:0];
    assign unused_mid_bits = ^instr[OPC_LSB-1:FN_W];
    assign cls             = classify(opc, fnc);
endmodule

// File: rtl/dbgc_slot_track.sv
module dbgc_slot_track (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic slot_in,
    input  logic cti_now,
    output logic in_slot
);
    logic prev_cti;

    always_ff @(posedge clk) begin
        if (rst)      prev_cti <= 1'b0;
        else if (adv) prev_cti <= cti_now;
    end

    assign in_slot = slot_in | prev_cti;
endmodule

// File: rtl/dbgc_fsm.sv
module dbgc_fsm
    import dbgc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       brk_seen,
    input  logic       host_suspend,
    input  logic       host_resume,
    input  logic       in_slot,
    input  logic       arb_en,
    output dbg_state_e state,
    output logic       cause_brk
);
    dbg_state_e nxt;
    logic       pend;
    logic       go;

    assign go = !in_slot && (brk_seen || host_suspend || pend);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (go)          nxt = ST_CLAIM;
            ST_CLAIM:   nxt = arb_en ? ST_HOLD : ST_WAIT_EN;
            ST_WAIT_EN: if (arb_en)      nxt = ST_HOLD;
            ST_HOLD:    if (host_resume) nxt = ST_RELEASE;
            ST_RELEASE: nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            pend      <= 1'b0;
            cause_brk <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IDLE) begin
                if (go) begin
                    pend      <= 1'b0;
                    cause_brk <= brk_seen;
                end else if (host_suspend) begin
                    pend <= 1'b1;
                end
            end
        end
    end

    // R4: no claim may begin while a delay slot is decoded
    a_r4_no_claim_in_slot: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && in_slot) |=> (state != ST_CLAIM));

    // R8: only resume leaves the hold, a suspend there changes nothing
    a_r8_hold_kept: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD && !host_resume) |=> (state == ST_HOLD));
endmodule

// File: rtl/dbgc_ack_gen.sv
module dbgc_ack_gen
    import dbgc_pkg::*;
(
    input  dbg_state_e state,
    input  logic       cause_brk,
    input  logic       arb_grant,
    output logic       ri_n,
    output logic       ack,
    output logic       brk_note,
    output logic       susp_ack
);
    always_comb begin
        ri_n     = 1'b1;
        ack      = 1'b0;
        brk_note = 1'b0;
        susp_ack = 1'b0;
        unique case (state)
            ST_CLAIM: begin
                ri_n     = 1'b0;
                brk_note = cause_brk;
            end
            ST_WAIT_EN: ri_n = 1'b0;
            ST_HOLD: begin
                ack      = 1'b1;
                susp_ack = arb_grant;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dbg_claim_ctrl.sv
module dbg_claim_ctrl
    import dbgc_pkg::*;
#(
    parameter int unsigned IW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] id_instr,
    input  logic          id_adv,
    input  logic          slot_in,
    input  logic          host_suspend,
    input  logic          host_resume,
    input  logic          arb_en,
    input  logic          arb_grant,
    output logic          ri_n,
    output logic          ack,
    output logic          brk_note,
    output logic          susp_ack
);
    insn_class_t cls;
    logic        in_slot;
    dbg_state_e  state;
    logic        cause_brk;

    dbgc_decode #(.IW(IW)) u_decode (
        .instr (id_instr),
        .cls   (cls)
    );

    dbgc_slot_track u_slot (
        .clk     (clk),
        .rst     (rst),
        .adv     (id_adv),
        .slot_in (slot_in),
        .cti_now (cls.br | cls.jmp),
        .in_slot (in_slot)
    );

    dbgc_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .brk_seen     (cls.brk),
        .host_suspend (host_suspend),
        .host_resume  (host_resume),
        .in_slot      (in_slot),
        .arb_en       (arb_en),
        .state        (state),
        .cause_brk    (cause_brk)
    );

    dbgc_ack_gen u_ack (
        .state     (state),
        .cause_brk (cause_brk),
        .arb_grant (arb_grant),
        .ri_n      (ri_n),
        .ack       (ack),
        .brk_note  (brk_note),
        .susp_ack  (susp_ack)
    );

    // R5: enable during a claim gives release of ri_n plus acknowledge
    a_r5_en_to_ack: assert property (@(posedge clk) disable iff (rst)
        (!ri_n && arb_en) |=> (ri_n && ack));

    // R6: stall report only under a held acknowledge and a grant
    a_r6_sack_gated: assert property (@(posedge clk) disable iff (rst)
        susp_ack |-> (ack && arb_grant));

    // R7: resume under acknowledge drops it next cycle
    a_r7_resume_drops: assert property (@(posedge clk) disable iff (rst)
        (ack && host_resume) |=> (!ack && !susp_ack));

    // R2: break notice lasts a single cycle
    a_r2_brk_pulse: assert property (@(posedge clk) disable iff (rst)
        brk_note |=> !brk_note);
endmodule

// File: tb/dbg_claim_ctrl_bench.sv
module dbg_claim_ctrl_bench;
    localparam int IW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic [IW-1:0] id_instr;
    logic          id_adv, slot_in, host_suspend, host_resume, arb_en, arb_grant;
    logic          ri_n, ack, brk_note, susp_ack;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    dbg_claim_ctrl #(.IW(IW)) u_dbg_claim_ctrl (
        .clk(clk), .rst(rst), .id_instr(id_instr), .id_adv(id_adv),
        .slot_in(slot_in), .host_suspend(host_suspend), .host_resume(host_resume),
        .arb_en(arb_en), .arb_grant(arb_grant), .ri_n(ri_n), .ack(ack),
        .brk_note(brk_note), .susp_ack(susp_ack)
    );

    localparam logic [31:0] I_BRK  = 32'h0000_000D;
    localparam logic [31:0] I_BEQ  = 32'h1000_0004;
    localparam logic [31:0] I_BGEZ = 32'h0401_0002;
    localparam logic [31:0] I_J    = 32'h0800_0010;
    localparam logic [31:0] I_JAL  = 32'h0C00_0010;
    localparam logic [31:0] I_JR   = 32'h03E0_0008;
    localparam logic [31:0] I_JALR = 32'h0040_F809;
    localparam logic [31:0] I_BGTZ = 32'h1C20_0003;
    localparam logic [31:0] I_ADDU = 32'h0022_1821;
    localparam logic [31:0] I_LW   = 32'h8C22_0000;

    // cycle model: 0 idle, 1 claim, 2 wait enable, 3 hold, 4 release
    int m_st;
    bit m_pend, m_cause, m_prev_cti;

    function automatic bit f_brk(input logic [31:0] w);
        return (w[31:26] == 6'd0) && (w[5:0] == 6'h0D);
    endfunction

    function automatic bit f_cti(input logic [31:0] w);
        logic [5:0] op = w[31:26];
        logic [5:0] fn = w[5:0];
        return (op == 6'd1) || (op >= 6'd2 && op <= 6'd7) ||
               (op == 6'd0 && (fn == 6'h08 || fn == 6'h09));
    endfunction

    function automatic bit e_ri_n();   return !(m_st == 1 || m_st == 2); endfunction
    function automatic bit e_ack();    return m_st == 3;                  endfunction
    function automatic bit e_brk();    return m_st == 1 && m_cause;       endfunction
    function automatic bit e_sack();   return m_st == 3 && arb_grant;     endfunction

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_update();
        bit in_slot = slot_in || m_prev_cti;
        bit b = f_brk(id_instr);
        bit go = !in_slot && (b || host_suspend || m_pend);
        if (rst) begin
            m_st = 0; m_pend = 0; m_cause = 0; m_prev_cti = 0;
            return;
        end
        case (m_st)
            0: begin
                if (go) begin m_st = 1; m_cause = b; m_pend = 0; end
                else if (host_suspend) m_pend = 1;
            end
            1: m_st = arb_en ? 3 : 2;
            2: if (arb_en) m_st = 3;
            3: if (host_resume) m_st = 4;
            default: m_st = 0;
        endcase
        if (id_adv) m_prev_cti = f_cti(id_instr);
    endtask

    // inputs already driven at negedge; sample, then advance one cycle
    task automatic step(input string tag);
        #1;
        chk(tag, "ri_n", ri_n, e_ri_n());
        chk(tag, "ack", ack, e_ack());
        chk(tag, "brk_note", brk_note, e_brk());
        chk(tag, "susp_ack", susp_ack, e_sack());
        model_update();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        rst = 0; id_instr = I_ADDU; id_adv = 0; slot_in = 0;
        host_suspend = 0; host_resume = 0; arb_en = 0; arb_grant = 0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd4242));
        idle_inputs();
        m_st = 0; m_pend = 0; m_cause = 0; m_prev_cti = 0;
        rst = 1;
        @(negedge clk);
        model_update();
        @(negedge clk);
        model_update();
        rst = 0;
        step("R1");

        // R2: break claimed, then enable late, grant, suspend during hold, resume
        id_instr = I_BRK; step("R2");
        id_instr = I_ADDU; step("R2");
        step("R5");
        arb_en = 1; step("R5");
        arb_en = 0; step("R5");
        arb_grant = 1; step("R6");
        host_suspend = 1; step("R8");
        host_suspend = 0; step("R8");
        host_resume = 1; step("R7");
        host_resume = 0; arb_grant = 0; step("R7");
        step("R8");
        step("R8");

        // R3: suspend claims any instruction, immediate enable
        id_instr = I_LW; host_suspend = 1; step("R3");
        host_suspend = 0; arb_en = 1; step("R3");
        arb_en = 0; step("R5");
        host_resume = 1; step("R7");
        host_resume = 0; step("R7");
        step("R7");

        // R4: suspend in the delay slot of a branch is deferred
        id_instr = I_BEQ; id_adv = 1; step("R4");
        id_instr = I_ADDU; id_adv = 0; host_suspend = 1; step("R4");
        host_suspend = 0; id_adv = 1; step("R4");
        id_adv = 0; step("R4");
        arb_en = 1; step("R4");
        arb_en = 0; host_resume = 1; step("R7");
        host_resume = 0; step("R7");
        step("R7");

        // R9: break in a delay slot from the hint and after each jump type
        id_instr = I_BRK; slot_in = 1; step("R9");
        step("R9");
        slot_in = 0;
        foreach (cti_list[k]) begin
            id_instr = cti_list[k]; id_adv = 1; step("R4");
            id_instr = I_BRK; id_adv = 0; step("R9");
            id_instr = I_ADDU; id_adv = 1; step("R9");
            id_adv = 0; step("R9");
        end
        // R7: resume outside a hold does nothing
        host_resume = 1; step("R7");
        host_resume = 0; step("R7");

        // random phase
        for (int i = 0; i < 6000; i++) begin
            int p = $urandom % 10;
            case (p)
                0: id_instr = I_BRK;  1: id_instr = I_BEQ;  2: id_instr = I_J;
                3: id_instr = I_JR;   4: id_instr = I_JALR; 5: id_instr = I_BGTZ;
                6: id_instr = I_BGEZ; 7: id_instr = I_JAL;  8: id_instr = I_LW;
                default: id_instr = I_ADDU;
            endcase
            id_adv       = ($urandom % 2) == 0;
            slot_in      = ($urandom % 8) == 0;
            host_suspend = ($urandom % 8) == 0;
            host_resume  = ($urandom % 6) == 0;
            arb_en       = ($urandom % 3) == 0;
            arb_grant    = ($urandom % 2) == 0;
            rst          = ($urandom % 500) == 0;
            step(rst ? "R1" : (i % 2 == 0) ? "R4" : "R6");
        end
        finish_run();
    end

    logic [31:0] cti_list [7] = '{I_BEQ, I_BGEZ, I_J, I_JAL, I_JR, I_JALR, I_BGTZ};
endmodule